// File: doc/BRIEF.md
# Strided Two-Dimensional DMA Address Walker

This block is the transfer engine of one channel of a two-dimensional DMA controller. Software loads a row length, a row stride, a row count minus one, a direction flag and a burst flag. It then presents a word-aligned start address with a launch strobe, and the launch begins the transfer. The walker issues one word address at a time on a request/acknowledge port. Each acknowledge moves it to the next word.

With a non-zero row length the walker runs a block transfer. It walks each row word by word, jumps to the start of the next row by the stride, and raises one completion pulse after the final word. With a row length of zero it runs as a circular buffer over stride × (count + 1) words. It raises a half-buffer pulse at the end of each half, wraps back to the start, and keeps running until a stop request retires it at the next acknowledged word.

Top module: `dma2d_walker`

## Requirements
- R1: After reset the channel is idle: `busy`, `wordReq`, `doneEvt` and `halfEvt` are all 0.
- R2: While idle, a cycle with `startValid` high captures every setting. From the next cycle `busy` and `wordReq` are 1 and `wordAddr` equals `startAddr`, which is a word address (byte address divided by four).
- R3: In block mode (row length L > 0, stride S, count C), the word acknowledged k-th carries address start + (k / L)·S + (k mod L). Exactly L·(C+1) words are issued.
- R4: In block mode `doneEvt` pulses for one cycle, in the cycle after the last word is acknowledged. In that same cycle `busy` falls. No other event is raised.
- R5: In loop mode (L = 0) the k-th acknowledged word carries start + (k mod N), where N = S·(C+1) must be even. The address wraps to the start after word N−1.
- R6: In loop mode `halfEvt` pulses in the cycle after the acknowledge of buffer index N/2−1, with `halfSel` = 0. It pulses again after index N−1, with `halfSel` = 1. This happens on every pass.
- R7: A cycle with `wordReq` high and `wordAck` low holds `wordAddr` and all progress.
- R8: In loop mode, `stopReq` takes effect at the next acknowledged word. That word is the last one, `busy` falls in the following cycle, and no event is raised for it.
- R9: `wordDir` (1 = memory to peripheral, 0 = peripheral to memory) and `wordBurst` (1 = four-word bursts, 0 = single words) keep the values captured at launch for the whole transfer.
- R10: `startValid` while busy is ignored: the address sequence and the flags continue unchanged, and no new transfer follows.
- R11: `stopReq` has no effect in block mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| startValid | input | 1 | Launch strobe, carrying the start address |
| startAddr | input | AW | Start word address |
| cfgRowLen | input | LW | Words per row; 0 selects loop mode |
| cfgStride | input | LW | Words from one row start to the next |
| cfgRowCnt | input | LW | Number of rows minus one |
| cfgDir | input | 1 | Direction flag |
| cfgBurst | input | 1 | Burst-size flag |
| stopReq | input | 1 | Ends a loop-mode transfer |
| wordReq | output | 1 | Word request |
| wordAck | input | 1 | Word acknowledge |
| wordAddr | output | AW | Current word address |
| wordDir | output | 1 | Captured direction |
| wordBurst | output | 1 | Captured burst flag |
| busy | output | 1 | Transfer in progress |
| doneEvt | output | 1 | Block completion pulse |
| halfEvt | output | 1 | Loop half-buffer pulse |
| halfSel | output | 1 | Which half ended (0 first, 1 second) |

## Verification
The assertions check four things on every cycle: a stall holds the address, a launch presents the start address, the two event kinds never coincide and a completion always leaves the channel idle, and a stop at an acknowledged word ends the transfer quietly. Only the bench scenarios can show the full address order across row jumps and wraps, where half-buffer events fall over several passes, and that mid-transfer launches and block-mode stops leave the sequence untouched. The bench sweeps small row lengths, gaps and row counts, each with and without acknowledge stalls.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
  // Strobes from control to the address datapath
  typedef struct packed {
    logic load;     // capture start address and stride
    logic step;     // advance one word
    logic nextRow;  // jump to next row start
    logic wrap;     // return to start of circular region
  } dpCmd_t;
endpackage

// File: rtl/dma2d_ctrl.sv
module dma2d_ctrl
  import dma2d_pkg::*;
#(
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startValid,
  input  logic [LW-1:0] cfgRowLen,
  input  logic [LW-1:0] cfgStride,
  input  logic [LW-1:0] cfgRowCnt,
  input  logic          cfgDir,
  input  logic          cfgBurst,
  input  logic          stopReq,
  input  logic          wordAck,
  output dpCmd_t        cmd,
  output logic          busy,
  output logic          dirQ,
  output logic          burstQ,
  output logic          doneEvt,
  output logic          halfEvt,
  output logic          halfSel
);
  localparam int RW = 2 * LW + 1;

  logic [LW-1:0] rowLenQ, rowCntQ, colQ, rowQ;
  logic [RW-1:0] idxQ, halfLastQ, regionLastQ, regionW;
  logic          loopQ;
  logic          accept, lastCol, lastRow, atHalf, atEnd, finish, blockDone, loopEvt;

  assign regionW   = RW'(cfgStride) * (RW'(cfgRowCnt) + RW'(1));
  assign accept    = busy & wordAck;
  assign lastCol   = (colQ == rowLenQ - LW'(1));
  assign lastRow   = (rowQ == rowCntQ);
  assign atHalf    = (idxQ == halfLastQ);
  assign atEnd     = (idxQ == regionLastQ);
  assign blockDone = accept & ~loopQ & lastCol & lastRow;
  assign loopEvt   = accept & loopQ & ~stopReq & (atHalf | atEnd);
  assign finish    = blockDone | (accept & loopQ & stopReq);

  always_comb begin
    cmd         = '0;
    cmd.load    = ~busy & startValid;
    cmd.step    = accept & (loopQ ? (~stopReq & ~atEnd) : ~lastCol);
    cmd.nextRow = accept & ~loopQ & lastCol & ~lastRow;
    cmd.wrap    = accept & loopQ & ~stopReq & atEnd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy        <= 1'b0;
      loopQ       <= 1'b0;
      dirQ        <= 1'b0;
      burstQ      <= 1'b0;
      rowLenQ     <= '0;
      rowCntQ     <= '0;
      colQ        <= '0;
      rowQ        <= '0;
      idxQ        <= '0;
      halfLastQ   <= '0;
      regionLastQ <= '0;
      doneEvt     <= 1'b0;
      halfEvt     <= 1'b0;
      halfSel     <= 1'b0;
    end else begin
      doneEvt <= blockDone;
      halfEvt <= loopEvt;
      if (loopEvt) halfSel <= atEnd;
      if (cmd.load) begin
        busy        <= 1'b1;
        loopQ       <= (cfgRowLen == '0);
        dirQ        <= cfgDir;
        burstQ      <= cfgBurst;
        rowLenQ     <= cfgRowLen;
        rowCntQ     <= cfgRowCnt;
        colQ        <= '0;
        rowQ        <= '0;
        idxQ        <= '0;
        halfLastQ   <= (regionW >> 1) - RW'(1);
        regionLastQ <= regionW - RW'(1);
      end else begin
        if (finish) busy <= 1'b0;
        if (cmd.step) begin
          if (loopQ) idxQ <= idxQ + RW'(1);
          else       colQ <= colQ + LW'(1);
        end
        if (cmd.nextRow) begin
          colQ <= '0;
          rowQ <= rowQ + LW'(1);
        end
        if (cmd.wrap) idxQ <= '0;
      end
    end
  end

  // R4: completion and half events never share a cycle
  p_one_event_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(doneEvt && halfEvt));
  // R4: completion leaves the channel idle
  p_done_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    doneEvt |-> !busy);
  // R8: an acknowledged word under stop in loop mode ends quietly
  p_stop_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (accept && loopQ && stopReq) |=> (!busy && !halfEvt));
  // R9: captured flags do not move during a transfer
  p_flags_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($stable(dirQ) && $stable(burstQ)));
endmodule

// File: rtl/dma2d_addr.sv
module dma2d_addr
  import dma2d_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpCmd_t        cmd,
  input  logic [AW-1:0] startAddr,
  input  logic [LW-1:0] cfgStride,
  output logic [AW-1:0] wordAddr
);
  logic [AW-1:0] baseQ, rowStartQ, strideQ, nextRowStart;

  assign nextRowStart = rowStartQ + strideQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ     <= '0;
      rowStartQ <= '0;
      strideQ   <= '0;
      wordAddr  <= '0;
    end else if (cmd.load) begin
      baseQ     <= startAddr;
      rowStartQ <= startAddr;
      strideQ   <= AW'(cfgStride);
      wordAddr  <= startAddr;
    end else if (cmd.nextRow) begin
      rowStartQ <= nextRowStart;
      wordAddr  <= nextRowStart;
    end else if (cmd.wrap) begin
      wordAddr  <= baseQ;
    end else if (cmd.step) begin
      wordAddr  <= wordAddr + AW'(1);
    end
  end

  // R2/R5: a wrap always returns to the launched start address
  p_wrap_base_r5: assert property (@(posedge clk) disable iff (!rstN)
    cmd.wrap |=> (wordAddr == baseQ));
endmodule

// File: rtl/dma2d_walker.sv
module dma2d_walker
  import dma2d_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startValid,
  input  logic [AW-1:0] startAddr,
  input  logic [LW-1:0] cfgRowLen,
  input  logic [LW-1:0] cfgStride,
  input  logic [LW-1:0] cfgRowCnt,
  input  logic          cfgDir,
  input  logic          cfgBurst,
  input  logic          stopReq,
  output logic          wordReq,
  input  logic          wordAck,
  output logic [AW-1:0] wordAddr,
  output logic          wordDir,
  output logic          wordBurst,
  output logic          busy,
  output logic          doneEvt,
  output logic          halfEvt,
  output logic          halfSel
);
  dpCmd_t cmd;

  dma2d_ctrl #(.LW(LW)) u_ctrl (
    .clk(clk), .rstN(rstN), .startValid(startValid),
    .cfgRowLen(cfgRowLen), .cfgStride(cfgStride), .cfgRowCnt(cfgRowCnt),
    .cfgDir(cfgDir), .cfgBurst(cfgBurst), .stopReq(stopReq), .wordAck(wordAck),
    .cmd(cmd), .busy(busy), .dirQ(wordDir), .burstQ(wordBurst),
    .doneEvt(doneEvt), .halfEvt(halfEvt), .halfSel(halfSel)
  );

  dma2d_addr #(.AW(AW), .LW(LW)) u_addr (
    .clk(clk), .rstN(rstN), .cmd(cmd), .startAddr(startAddr),
    .cfgStride(cfgStride), .wordAddr(wordAddr)
  );

  assign wordReq = busy;

  // R7: a stalled request holds its address
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wordReq && !wordAck) |=> $stable(wordAddr));
  // R2: a fresh transfer presents the launched address
  p_launch_addr_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startValid) |=> (busy && wordAddr == $past(startAddr)));
endmodule

// File: tb/dma2d_walker_bench.sv
module dma2d_walker_bench;
  localparam int AW = 32;
  localparam int LW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startValid = 1'b0;
  logic [AW-1:0] startAddr = '0;
  logic [LW-1:0] cfgRowLen = '0, cfgStride = '0, cfgRowCnt = '0;
  logic          cfgDir = 1'b0, cfgBurst = 1'b0, stopReq = 1'b0, wordAck = 1'b0;
  logic          wordReq, wordDir, wordBurst, busy, doneEvt, halfEvt, halfSel;
  logic [AW-1:0] wordAddr;

  int vectors = 0;
  int miscompares = 0;

  always #5 clk = ~clk;

  dma2d_walker #(.AW(AW), .LW(LW)) u_dma2d_walker (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startAddr(startAddr),
    .cfgRowLen(cfgRowLen), .cfgStride(cfgStride), .cfgRowCnt(cfgRowCnt),
    .cfgDir(cfgDir), .cfgBurst(cfgBurst), .stopReq(stopReq),
    .wordReq(wordReq), .wordAck(wordAck), .wordAddr(wordAddr),
    .wordDir(wordDir), .wordBurst(wordBurst), .busy(busy),
    .doneEvt(doneEvt), .halfEvt(halfEvt), .halfSel(halfSel)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // One transfer: block (rl>0) or loop (rl==0). stopAt: loop word index at which stop rises.
  task automatic runXfer(input int start, input int rl, input int st, input int rc,
                         input bit stall, input int stopAt, input bit dir,
                         input bit burst, input bit poke);
    bit loopMode = (rl == 0);
    int total = rl * (rc + 1);
    int region = st * (rc + 1);
    int k = 0;
    int cyc = 0;
    bit expDone = 0, expHalf = 0, expSel = 0, ending = 0, ack;
    longint ea;
    @(negedge clk);
    startAddr = AW'(start); cfgRowLen = LW'(rl); cfgStride = LW'(st);
    cfgRowCnt = LW'(rc); cfgDir = dir; cfgBurst = burst; startValid = 1'b1;
    @(negedge clk);
    startValid = 1'b0;
    while (1) begin
      chk(doneEvt == expDone, "R4 doneEvt", doneEvt, expDone);
      chk(halfEvt == expHalf, "R6 halfEvt", halfEvt, expHalf);
      if (expHalf) chk(halfSel == expSel, "R6 halfSel", halfSel, expSel);
      if (ending) begin
        chk(busy == 1'b0, loopMode ? "R8 idle after stop" : "R4 idle after done", busy, 0);
        @(negedge clk);
        chk(busy == 1'b0, "R10 no deferred launch", busy, 0);
        break;
      end
      if (loopMode) ea = start + (k % region);
      else ea = start + (k / rl) * st + (k % rl);
      chk(wordReq == 1'b1, "R2 wordReq", wordReq, 1);
      chk(wordAddr == AW'(ea), loopMode ? "R5 loop address" : "R3 block address", wordAddr, ea);
      chk(wordDir == dir && wordBurst == burst, "R9 flags", {wordDir, wordBurst}, {dir, burst});
      if (poke && k == 1) begin
        startValid = 1'b1; startAddr = AW'(start + 'h100);
        cfgDir = ~dir; cfgBurst = ~burst;
        if (!loopMode) stopReq = 1'b1;  // R11
      end else startValid = 1'b0;
      if (loopMode && k == stopAt) stopReq = 1'b1;
      ack = stall ? ((cyc % 3) != 1) : 1'b1;
      cyc++;
      wordAck = ack;
      expDone = 0; expHalf = 0;
      if (ack) begin
        if (loopMode) begin
          if (stopReq) ending = 1;
          else begin
            int idx = k % region;
            if (idx == region / 2 - 1) begin expHalf = 1; expSel = 0; end
            if (idx == region - 1) begin expHalf = 1; expSel = 1; end
          end
        end else if (k == total - 1) begin
          expDone = 1; ending = 1;
        end
        k++;
      end
      @(negedge clk);
    end
    wordAck = 1'b0; stopReq = 1'b0; startValid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy == 0 && wordReq == 0, "R1 reset idle", {busy, wordReq}, 0);
    chk(doneEvt == 0 && halfEvt == 0, "R1 reset events", {doneEvt, halfEvt}, 0);
    // R3 R4 R7: block sweep over row length, gap, rows, stall
    for (int rl = 1; rl <= 3; rl++)
      for (int gap = 0; gap <= 2; gap++)
        for (int rc = 0; rc <= 2; rc++)
          for (int s = 0; s <= 1; s++)
            runXfer(32'h40 + rl * 16 + gap, rl, rl + gap, rc, s[0], 0,
                    rl[0], gap[0], 1'b0);
    // R5 R6 R8: loop sweep, stop after two passes plus one word
    for (int si = 0; si <= 1; si++)
      for (int rc = 0; rc <= 2; rc++)
        for (int s = 0; s <= 1; s++) begin
          int st = 2 + 2 * si;
          runXfer(32'h200 + rc, 0, st, rc, s[0], 2 * st * (rc + 1) + 1, 1'b1, 1'b0, 1'b0);
        end
    // R6: odd stride with odd row count gives even region
    runXfer(32'h300, 0, 3, 1, 1'b1, 13, 1'b0, 1'b1, 1'b0);
    // R8: stop lands on a half boundary, no event
    runXfer(32'h380, 0, 2, 1, 1'b0, 5, 1'b0, 1'b0, 1'b0);
    // R10 R11 R9: launch, flag change and stop while a block runs
    runXfer(32'h400, 3, 5, 2, 1'b1, 0, 1'b1, 1'b1, 1'b1);
    // R10: launch while looping is ignored
    runXfer(32'h480, 0, 4, 1, 1'b0, 9, 1'b0, 1'b1, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule